// File: doc/BRIEF.md
# ADC Result Post-Processing Unit

This unit sits behind an analog-to-digital converter and treats every conversion word it receives according to a selected mode. In pass-through mode it forwards each word unchanged. In accumulate mode it sums the words. In average mode it sums a fixed number of words and emits their scaled sum. In burst mode one trigger starts a run of back-to-back conversions, which are averaged the same way. In low-pass mode it runs a first-order recursive filter with unity DC gain. One shared accumulator, one scale shift and one sample counter serve all the summing and filtering modes.

A control port selects the mode, the shift amount, the repeat count and the source of the previous-sample register. It also carries a clear command that runs as a handshake and drops its own busy flag when the wipe is done. Each start-of-conversion pulse copies either the last raw word or the processed output into the previous-sample register. In burst mode the same pulse arms a conversion request toward the converter.

Top module: `adc_postproc`

## Requirements
- R1: After reset, out_data, acc, smp_cnt, prev, ovf, out_done, clr_busy and conv_req are all 0. The mode is 000 (pass-through) and the previous-sample source is raw.
- R2: In mode 000, and in the reserved modes 101, 110 and 111, each accepted word appears zero-extended on out_data with out_done high for one cycle. The shift field has no effect, and acc, smp_cnt and ovf are not changed.
- R3: In mode 001 (accumulate), each word is added to acc and smp_cnt goes up by one, saturating at its maximum. out_data becomes the new acc right-shifted by the shift field, and out_done pulses for every word.
- R4: In mode 010 (average), a word that brings smp_cnt+1 to at least the repeat count sets out_data to (acc+word) right-shifted and pulses out_done. It also zeroes acc and smp_cnt. Any other word is summed with out_done low and out_data held. With repeat = 2^shift, out_data is the mean.
- R5: In mode 011 (burst), a start pulse while idle zeroes acc and smp_cnt and raises conv_req. Words are summed only while conv_req is high. The word that completes the repeat count produces the result as in R4 and drops conv_req. Words that arrive while idle change nothing.
- R6: In mode 100 (low-pass), each word updates acc to acc + word - (acc >> shift), and out_data becomes the new acc >> shift. out_done pulses for every word. A constant input x settles to out_data = x.
- R7: A shift field value of 111 is treated as a shift of 0 in every mode.
- R8: ovf sets when an update of acc carries out of the accumulator width (DW+6 bits), and acc keeps the wrapped low bits. ovf then stays set until a clear.
- R9: A clear command while not busy holds clr_busy high for exactly CLR_CYCLES cycles. clr_busy then falls on the same edge that zeroes acc, smp_cnt and ovf, and that wipe overrides a word arriving in the same cycle. A clear command while busy is ignored.
- R10: On each start pulse, prev loads out_data when prev_sel is 1 and the last accepted raw word when prev_sel is 0.
- R11: out_data, out_done, acc, smp_cnt and ovf change on the first clock edge after the word is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 3 | Mode select |
| cfg_shift | input | 3 | Shift / filter time-constant exponent |
| cfg_repeat | input | RPW (7) | Words per average or burst |
| cfg_prev_sel | input | 1 | Previous-sample source: 1 processed output, 0 raw |
| clr_cmd | input | 1 | Clear command pulse |
| soc | input | 1 | Start-of-conversion pulse |
| res_valid | input | 1 | Conversion word strobe |
| res_data | input | DW (10) | Conversion word |
| out_data | output | DW+6 | Shifted or filtered result |
| out_done | output | 1 | One-cycle result pulse |
| acc | output | DW+6 | Accumulator |
| smp_cnt | output | RPW | Sample counter |
| ovf | output | 1 | Sticky overflow |
| prev | output | DW+6 | Previous-sample register |
| clr_busy | output | 1 | Clear in progress |
| conv_req | output | 1 | Burst conversion request |

## Verification
A corrupted accumulator or counter shows up one edge later on acc and smp_cnt. It also shows up on out_data at the next completing word, so every word presented to the unit is compared against a bench model on the following cycle. A wrong shift or mode decode changes out_data at once, because each word is checked under random mode, shift and repeat settings. Errors in the clear sequencer appear as a busy flag of the wrong length, or as leftover state at the edge where busy falls, and both are checked cycle by cycle. Overflow is driven across its boundary so that a missing sticky bit is seen on the very word that carries out.

// File: rtl/adc_pp_pkg.sv
package adc_pp_pkg;

    typedef enum logic [2:0] {
        MODE_PASS  = 3'b000,
        MODE_ACC   = 3'b001,
        MODE_AVG   = 3'b010,
        MODE_BURST = 3'b011,
        MODE_LPF   = 3'b100
    } pp_mode_e;

    localparam int SHW = 3;

    // Shift code 7 is invalid and behaves as 0.
    function automatic logic [SHW-1:0] eff_shift(input logic [SHW-1:0] s);
        return (s == 3'b111) ? '0 : s;
    endfunction

endpackage

// File: rtl/adc_pp_clear.sv
module adc_pp_clear #(
    parameter int CLR_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_cmd,
    output logic busy,
    output logic wipe
);
    localparam int TW = $clog2(CLR_CYCLES + 1);
    localparam logic [TW-1:0] LAST = TW'(CLR_CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic [TW-1:0] tmr;
    } clr_t;

    clr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!s_q.busy) begin
            if (clr_cmd) begin
                s_d.busy = 1'b1;
                s_d.tmr  = '0;
            end
        end else if (s_q.tmr == LAST) begin
            s_d.busy = 1'b0;
        end else begin
            s_d.tmr = s_q.tmr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign wipe = s_q.busy && (s_q.tmr == LAST);

    // Independent run-length counter for the busy window
    logic [TW:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_q <= '0;
        else if (busy)   run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    a_r9_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= (TW+1)'(CLR_CYCLES));
    a_r9_wipe_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> !busy);
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wipe) |=> busy);

endmodule

// File: rtl/adc_pp_prev.sv
module adc_pp_prev #(
    parameter int DW = 10,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          res_valid,
    input  logic [DW-1:0] res_data,
    input  logic          soc,
    input  logic          prev_sel,
    input  logic [AW-1:0] proc_out,
    output logic [AW-1:0] prev
);
    typedef struct packed {
        logic [DW-1:0] raw;
        logic [AW-1:0] prev;
    } prv_t;

    prv_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (res_valid) s_d.raw = res_data;
        if (soc) begin
            s_d.prev = prev_sel ? proc_out : {{(AW-DW){1'b0}}, s_q.raw};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign prev = s_q.prev;

    a_r10_prev_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !soc |=> $stable(prev));
    a_r10_prev_filtered: assert property (@(posedge clk) disable iff (!rst_n)
        (soc && prev_sel) |=> (prev == $past(proc_out)));

endmodule

// File: rtl/adc_pp_core.sv
module adc_pp_core
    import adc_pp_pkg::*;
#(
    parameter int DW  = 10,
    parameter int AW  = 16,
    parameter int RPW = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     cfg_mode,
    input  logic [SHW-1:0] cfg_shift,
    input  logic [RPW-1:0] cfg_repeat,
    input  logic           soc,
    input  logic           smp_valid,
    input  logic [DW-1:0]  smp_data,
    input  logic           wipe,
    output logic [AW-1:0]  out_data,
    output logic           out_done,
    output logic [AW-1:0]  acc,
    output logic [RPW-1:0] cnt,
    output logic           ovf,
    output logic           active
);
    localparam logic [RPW-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [AW-1:0]  acc;
        logic [RPW-1:0] cnt;
        logic           ovf;
        logic [AW-1:0]  out;
        logic           done;
        logic           active;
    } core_t;

    core_t s_d, s_q;

    logic [SHW-1:0] sh;
    logic [AW-1:0]  ext;
    logic [AW:0]    sum;
    logic [AW:0]    fsum;
    logic [RPW-1:0] cnt_inc;
    logic           reach;

    always_comb begin
        sh      = eff_shift(cfg_shift);
        ext     = {{(AW-DW){1'b0}}, smp_data};
        sum     = {1'b0, s_q.acc} + {1'b0, ext};
        fsum    = sum - {1'b0, (s_q.acc >> sh)};
        cnt_inc = (s_q.cnt == CNT_MAX) ? s_q.cnt : s_q.cnt + 1'b1;
        reach   = (cnt_inc >= cfg_repeat);

        s_d      = s_q;
        s_d.done = 1'b0;

        case (cfg_mode)
            MODE_ACC: if (smp_valid) begin
                s_d.acc  = sum[AW-1:0];
                s_d.ovf  = s_q.ovf | sum[AW];
                s_d.cnt  = cnt_inc;
                s_d.out  = sum[AW-1:0] >> sh;
                s_d.done = 1'b1;
            end
            MODE_AVG: if (smp_valid) begin
                s_d.ovf = s_q.ovf | sum[AW];
                if (reach) begin
                    s_d.out  = sum[AW-1:0] >> sh;
                    s_d.done = 1'b1;
                    s_d.acc  = '0;
                    s_d.cnt  = '0;
                end else begin
                    s_d.acc = sum[AW-1:0];
                    s_d.cnt = cnt_inc;
                end
            end
            MODE_BURST: begin
                if (!s_q.active) begin
                    if (soc) begin
                        s_d.active = 1'b1;
                        s_d.acc    = '0;
                        s_d.cnt    = '0;
                    end
                end else if (smp_valid) begin
                    s_d.ovf = s_q.ovf | sum[AW];
                    if (reach) begin
                        s_d.out    = sum[AW-1:0] >> sh;
                        s_d.done   = 1'b1;
                        s_d.acc    = '0;
                        s_d.cnt    = '0;
                        s_d.active = 1'b0;
                    end else begin
                        s_d.acc = sum[AW-1:0];
                        s_d.cnt = cnt_inc;
                    end
                end
            end
            MODE_LPF: if (smp_valid) begin
                s_d.acc  = fsum[AW-1:0];
                s_d.ovf  = s_q.ovf | fsum[AW];
                s_d.cnt  = cnt_inc;
                s_d.out  = fsum[AW-1:0] >> sh;
                s_d.done = 1'b1;
            end
            default: if (smp_valid) begin
                s_d.out  = ext;
                s_d.done = 1'b1;
            end
        endcase

        if (cfg_mode != MODE_BURST) s_d.active = 1'b0;

        if (wipe) begin
            s_d.acc = '0;
            s_d.cnt = '0;
            s_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_data = s_q.out;
    assign out_done = s_q.done;
    assign acc      = s_q.acc;
    assign cnt      = s_q.cnt;
    assign ovf      = s_q.ovf;
    assign active   = s_q.active;

    logic pass_like;
    assign pass_like = (cfg_mode == MODE_PASS) || (cfg_mode > MODE_LPF);

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !wipe) |=> ovf);
    a_r2_pass_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_like && !wipe) |=> $stable(acc));
    a_r5_idle_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == MODE_BURST && !active && !soc && !wipe) |=> ($stable(acc) && !out_done));
    a_r9_wipe_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (acc == '0 && cnt == '0 && !ovf));
    a_r11_done_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> $past(smp_valid));

endmodule

// File: rtl/adc_postproc.sv
module adc_postproc
    import adc_pp_pkg::*;
#(
    parameter int DW         = 10,
    parameter int ACC_GROW   = 6,
    parameter int RPW        = 7,
    parameter int CLR_CYCLES = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           cfg_mode,
    input  logic [2:0]           cfg_shift,
    input  logic [RPW-1:0]       cfg_repeat,
    input  logic                 cfg_prev_sel,
    input  logic                 clr_cmd,
    input  logic                 soc,
    input  logic                 res_valid,
    input  logic [DW-1:0]        res_data,
    output logic [DW+ACC_GROW-1:0] out_data,
    output logic                 out_done,
    output logic [DW+ACC_GROW-1:0] acc,
    output logic [RPW-1:0]       smp_cnt,
    output logic                 ovf,
    output logic [DW+ACC_GROW-1:0] prev,
    output logic                 clr_busy,
    output logic                 conv_req
);
    localparam int AW = DW + ACC_GROW;

    logic wipe;

    adc_pp_clear #(.CLR_CYCLES(CLR_CYCLES)) u_clear (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_cmd (clr_cmd),
        .busy    (clr_busy),
        .wipe    (wipe)
    );

    adc_pp_core #(.DW(DW), .AW(AW), .RPW(RPW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_mode   (cfg_mode),
        .cfg_shift  (cfg_shift),
        .cfg_repeat (cfg_repeat),
        .soc        (soc),
        .smp_valid  (res_valid),
        .smp_data   (res_data),
        .wipe       (wipe),
        .out_data   (out_data),
        .out_done   (out_done),
        .acc        (acc),
        .cnt        (smp_cnt),
        .ovf        (ovf),
        .active     (conv_req)
    );

    adc_pp_prev #(.DW(DW), .AW(AW)) u_prev (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .res_data  (res_data),
        .soc       (soc),
        .prev_sel  (cfg_prev_sel),
        .proc_out  (out_data),
        .prev      (prev)
    );

endmodule

// File: tb/adc_postproc_tb.sv
module adc_postproc_tb;
    localparam int DW = 10;
    localparam int AW = 16;
    localparam int RPW = 7;
    localparam int CLRC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] cfg_mode = '0, cfg_shift = '0;
    logic [RPW-1:0] cfg_repeat = '0;
    logic cfg_prev_sel = 1'b0, clr_cmd = 1'b0, soc = 1'b0, res_valid = 1'b0;
    logic [DW-1:0] res_data = '0;
    logic [AW-1:0] out_data, acc, prev;
    logic [RPW-1:0] smp_cnt;
    logic out_done, ovf, clr_busy, conv_req;

    adc_postproc #(.DW(DW), .ACC_GROW(6), .RPW(RPW), .CLR_CYCLES(CLRC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_shift(cfg_shift),
        .cfg_repeat(cfg_repeat), .cfg_prev_sel(cfg_prev_sel), .clr_cmd(clr_cmd),
        .soc(soc), .res_valid(res_valid), .res_data(res_data), .out_data(out_data),
        .out_done(out_done), .acc(acc), .smp_cnt(smp_cnt), .ovf(ovf), .prev(prev),
        .clr_busy(clr_busy), .conv_req(conv_req)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_err = 0;
    bit finished = 1'b0;

    // bench model state
    logic [AW-1:0] m_acc = '0, m_out = '0, m_prev = '0;
    logic [RPW-1:0] m_cnt = '0;
    logic m_ovf = 0, m_done = 0, m_act = 0;
    logic [DW-1:0] m_raw = '0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "out_data", out_data, m_out);
        chk(req, "out_done", out_done, m_done);
        chk(req, "acc", acc, m_acc);
        chk(req, "smp_cnt", smp_cnt, m_cnt);
        chk(req, "ovf", ovf, m_ovf);
        chk(req, "conv_req", conv_req, m_act);
    endtask

    function automatic int shv(input logic [2:0] s);
        return (s == 3'd7) ? 0 : int'(s);
    endfunction

    task automatic model_word(input logic [DW-1:0] x);
        longint s, f;
        logic [RPW-1:0] ci;
        int sh;
        sh = shv(cfg_shift);
        s = longint'(m_acc) + longint'(x);
        ci = (m_cnt == '1) ? m_cnt : m_cnt + 1'b1;
        m_done = 0;
        m_raw = x;
        case (cfg_mode)
            3'd1: begin
                m_acc = AW'(s); m_ovf |= (s >= 65536); m_cnt = ci;
                m_out = m_acc >> sh; m_done = 1;
            end
            3'd2, 3'd3: if (cfg_mode == 3'd2 || m_act) begin
                m_ovf |= (s >= 65536);
                if (ci >= cfg_repeat) begin
                    m_out = AW'(s) >> sh; m_done = 1; m_acc = 0; m_cnt = 0; m_act = 0;
                end else begin
                    m_acc = AW'(s); m_cnt = ci;
                end
            end
            3'd4: begin
                f = s - longint'(m_acc >> sh);
                m_acc = AW'(f); m_ovf |= (f >= 65536); m_cnt = ci;
                m_out = m_acc >> sh; m_done = 1;
            end
            default: begin m_out = AW'(x); m_done = 1; end
        endcase
    endtask

    task automatic send(input logic [DW-1:0] x, input string req);
        res_valid = 1; res_data = x;
        @(negedge clk);
        res_valid = 0;
        model_word(x);
        chk_all(req);
    endtask

    task automatic start_pulse(input string req);
        soc = 1;
        @(negedge clk);
        soc = 0;
        m_prev = cfg_prev_sel ? m_out : AW'(m_raw);
        m_done = 0;
        if (cfg_mode == 3'd3 && !m_act) begin m_act = 1; m_acc = 0; m_cnt = 0; end
        chk(req, "prev", prev, m_prev);
        chk_all(req);
    endtask

    task automatic set_cfg(input logic [2:0] md, input logic [2:0] sh, input int rp);
        cfg_mode = md; cfg_shift = sh; cfg_repeat = RPW'(rp);
        if (md != 3'd3) m_act = 0;
        @(negedge clk);
        m_done = 0;
    endtask

    task automatic do_clear(input string req);
        clr_cmd = 1;
        @(negedge clk);
        clr_cmd = 0;
        m_done = 0;
        for (int i = 0; i < CLRC; i++) begin
            chk(req, "clr_busy high", clr_busy, 1);
            if (i == CLRC - 1) begin
                // word in the wipe cycle is overridden for acc/cnt/ovf
                res_valid = 1; res_data = 10'd77;
            end
            @(negedge clk);
            res_valid = 0;
            if (i == CLRC - 1) begin
                model_word(10'd77);
                m_acc = 0; m_cnt = 0; m_ovf = 0;
            end else m_done = 0;
        end
        chk(req, "clr_busy low", clr_busy, 0);
        chk_all(req);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk_all("R1");
        chk("R1", "prev", prev, 0);
        chk("R1", "clr_busy", clr_busy, 0);
        rst_n = 1;
        @(negedge clk);

        // R2 pass-through, shift ignored; R11 one-edge latency
        set_cfg(3'd0, 3'd5, 4);
        send(10'd513, "R2");
        send(10'd1023, "R11");
        // R10 raw source
        start_pulse("R10");

        // R3 accumulate with shift 1
        set_cfg(3'd1, 3'd1, 0);
        send(10'd100, "R3"); send(10'd301, "R3"); send(10'd7, "R3");
        // R2 reserved mode leaves acc
        set_cfg(3'd6, 3'd2, 0);
        send(10'd900, "R2");
        // R7 shift code 7
        set_cfg(3'd1, 3'd7, 0);
        send(10'd5, "R7");
        chk("R7", "out equals acc", out_data, acc);
        // R10 processed source
        cfg_prev_sel = 1;
        start_pulse("R10");
        cfg_prev_sel = 0;
        // R9 clear
        do_clear("R9");

        // R4 average, 4 words at shift 2
        set_cfg(3'd2, 3'd2, 4);
        send(10'd10, "R4"); send(10'd20, "R4"); send(10'd30, "R4"); send(10'd44, "R4");
        chk("R4", "mean", out_data, 26);
        send(10'd8, "R4");

        // R5 burst
        set_cfg(3'd3, 3'd1, 2);
        send(10'd500, "R5"); // idle: ignored
        start_pulse("R5");
        chk("R5", "conv_req up", conv_req, 1);
        send(10'd200, "R5"); send(10'd300, "R5");
        chk("R5", "burst mean", out_data, 250);
        chk("R5", "conv_req down", conv_req, 0);
        send(10'd600, "R5");

        // R6 low-pass step to constant
        do_clear("R9");
        set_cfg(3'd4, 3'd2, 0);
        for (int i = 0; i < 60; i++) send(10'd400, "R6");
        chk("R6", "unity gain", out_data, 400);

        // R8 overflow
        do_clear("R9");
        set_cfg(3'd1, 3'd0, 0);
        for (int i = 0; i < 70; i++) send(10'd1023, "R8");
        chk("R8", "ovf set", ovf, 1);
        set_cfg(3'd0, 3'd0, 0);
        send(10'd3, "R8");
        chk("R8", "ovf sticky", ovf, 1);
        do_clear("R9");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int pick;
            pick = $urandom_range(0, 9);
            if (pick == 0) begin
                logic [2:0] md;
                md = 3'($urandom_range(0, 7));
                if (md == 3'd3) md = 3'd2;
                set_cfg(md, 3'($urandom_range(0, 7)), 0);
                cfg_repeat = RPW'(1 << shv(cfg_shift));
            end else if (pick == 1) begin
                cfg_prev_sel = 1'($urandom_range(0, 1));
                start_pulse("R10");
            end else if (pick == 2 && i % 50 == 0) begin
                do_clear("R9");
            end else begin
                send(DW'($urandom_range(0, 1023)), "R3");
            end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule